// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel NOR flash model. It watches the write cycles of a synchronous bus (a write strobe, an address and a data byte). Most commands begin with a fixed two-cycle unlock prefix, and the block recognises the command sequences that follow it: byte program, sector erase, whole-array erase, identification entry and identification exit. When a sequence completes, the block emits a one-cycle operation request to a separate executor. The request carries an operation type, a target address and the final data byte. The executor answers with a busy level, and while that level is high every command write is dropped.

The block also holds an identification-mode flag. While the flag is set, reads return a manufacturer byte or a device byte, chosen by address bit 0. Otherwise reads return the array data that arrives on the read-data input. Cycles without a write strobe are treated as reads. They never change the progress of a sequence, so a host may read between the writes of a command.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, the identification flag is 0, no request is pending, and the sequence state is idle, so a lone program-data write produces no request.
- R2: A program request is raised by four writes: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then any address with any data. It is a one-cycle `req_valid` pulse in the cycle after the fourth write, with `req_op`=01, `req_addr` equal to the fourth write's full address and `req_data` equal to its data. Only address bits 14..0 are compared in the command cycles.
- R3: A sector erase is raised by these writes in order: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. The request has `req_op`=10, and `req_addr` is the sixth address with bits SECTOR_BITS-1..0 cleared (4 KB sectors by default).
- R4: The same prefix ending in 10h at 5555h raises an array erase with `req_op`=11 and `req_addr`=0. The value 10h at any other address raises nothing.
- R5: The writes AAh@5555h, 55h@2AAAh, 90h@5555h set the identification flag. While the flag is set, `rd_data` is BFh when address bit 0 is 0 and DEV_CODE when it is 1. While the flag is clear, `rd_data` equals `arr_rdata`.
- R6: The flag is cleared by either of two exits: the three-cycle exit ending in F0h at 5555h, or a single write of F0h at any address while the sequence is idle.
- R7: A write that does not match the pair expected at its step returns the sequence to idle without issuing a request, and the next command must start again from the first unlock write.
- R8: While `exec_busy` is 1, writes are ignored. They do not advance the sequence, do not abort it, raise no request, and do not change the identification flag, including for an exit command.
- R9: Cycles with `wr_en` low, with any address, leave the sequence state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | ADDR_W | Byte address of the current cycle |
| wdata | input | 8 | Write data byte |
| exec_busy | input | 1 | Executor is running an operation |
| arr_rdata | input | 8 | Array read data from the storage model |
| req_valid | output | 1 | One-cycle operation request pulse |
| req_op | output | 2 | 01 program, 10 sector erase, 11 array erase |
| req_addr | output | ADDR_W | Target byte, aligned sector base, or 0 |
| req_data | output | 8 | Data byte of the final write |
| id_mode | output | 1 | Identification mode flag |
| rd_data | output | 8 | Read data after the identification mux |

## Verification
The bench builds the block with ADDR_W=17 and DEV_CODE=D5h. The two address bits above the 15-bit compare window can then be set in command cycles to show they are ignored. Sector bases at 64 KB and above show that the alignment keeps the upper bits. The non-default device byte shows that the identification read follows the parameter and is not a built-in constant.

// File: rtl/nor_cmd_pkg.sv
`timescale 1ns/1ps
package nor_cmd_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_PROG = 2'b01,
      OP_SECT = 2'b10,
      OP_CHIP = 2'b11
   } nor_op_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_UNL1,
      S_UNL2,
      S_PROG,
      S_ERA1,
      S_ERA2,
      S_ERA3
   } seq_st_e;

   localparam int          CMP_W    = 15;
   localparam logic [14:0] ADR_CMD  = 15'h5555;
   localparam logic [14:0] ADR_ALT  = 15'h2AAA;
   localparam logic [7:0]  D_KEY1   = 8'hAA;
   localparam logic [7:0]  D_KEY2   = 8'h55;
   localparam logic [7:0]  D_PROG   = 8'hA0;
   localparam logic [7:0]  D_ERASE  = 8'h80;
   localparam logic [7:0]  D_IDIN   = 8'h90;
   localparam logic [7:0]  D_IDOUT  = 8'hF0;
   localparam logic [7:0]  D_SECT   = 8'h30;
   localparam logic [7:0]  D_CHIP   = 8'h10;
   localparam logic [7:0]  MFR_CODE = 8'hBF;

   localparam int          N_KEYS    = 2;
   localparam logic [29:0] KEY_ADRS  = {ADR_ALT, ADR_CMD};
   localparam logic [15:0] KEY_DATAS = {D_KEY2, D_KEY1};
endpackage

// File: rtl/nor_cyc_match.sv
`timescale 1ns/1ps
module nor_cyc_match #(
   parameter logic [14:0] MATCH_ADDR = 15'h5555,
   parameter logic [7:0]  MATCH_DATA = 8'hAA
) (
   input  logic [14:0] cmp_addr,
   input  logic [7:0]  cmp_data,
   output logic        hit
);
   assign hit = (cmp_addr == MATCH_ADDR) && (cmp_data == MATCH_DATA);
endmodule

// File: rtl/nor_seq_fsm.sv
`timescale 1ns/1ps
module nor_seq_fsm
   import nor_cmd_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int SECTOR_BITS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic [N_KEYS-1:0] key_hit,
   output logic              req_valid,
   output logic [1:0]        req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   output logic              id_mode
);
   localparam int UPPER_W = ADDR_W - SECTOR_BITS;

   seq_st_e           st_q, st_nxt;
   logic              id_nxt;
   logic              fire;
   nor_op_e           op_nxt, op_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic              at_cmd;
   logic              take;

   assign at_cmd = (addr[CMP_W-1:0] == ADR_CMD);
   assign take   = wr_en && !busy;

   always_comb begin
      st_nxt   = S_IDLE;
      id_nxt   = id_mode;
      fire     = 1'b0;
      op_nxt   = OP_NONE;
      addr_nxt = '0;
      case (st_q)
         S_IDLE: begin
            if (wdata == D_IDOUT) id_nxt = 1'b0;
            else if (key_hit[0])  st_nxt = S_UNL1;
         end
         S_UNL1: if (key_hit[1]) st_nxt = S_UNL2;
         S_UNL2: begin
            if (at_cmd) begin
               case (wdata)
                  D_PROG:  st_nxt = S_PROG;
                  D_ERASE: st_nxt = S_ERA1;
                  D_IDIN:  id_nxt = 1'b1;
                  D_IDOUT: id_nxt = 1'b0;
                  default: st_nxt = S_IDLE;
               endcase
            end
         end
         S_PROG: begin
            fire     = 1'b1;
            op_nxt   = OP_PROG;
            addr_nxt = addr;
         end
         S_ERA1: if (key_hit[0]) st_nxt = S_ERA2;
         S_ERA2: if (key_hit[1]) st_nxt = S_ERA3;
         S_ERA3: begin
            if (wdata == D_SECT) begin
               fire     = 1'b1;
               op_nxt   = OP_SECT;
               addr_nxt = {addr[ADDR_W-1 -: UPPER_W], {SECTOR_BITS{1'b0}}};
            end else if ((wdata == D_CHIP) && at_cmd) begin
               fire     = 1'b1;
               op_nxt   = OP_CHIP;
               addr_nxt = '0;
            end
         end
         default: st_nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         id_mode   <= 1'b0;
         req_valid <= 1'b0;
         op_q      <= OP_NONE;
         req_addr  <= '0;
         req_data  <= '0;
      end else begin
         req_valid <= 1'b0;
         if (take) begin
            st_q    <= st_nxt;
            id_mode <= id_nxt;
            if (fire) begin
               req_valid <= 1'b1;
               op_q      <= op_nxt;
               req_addr  <= addr_nxt;
               req_data  <= wdata;
            end
         end
      end
   end

   assign req_op = op_q;
endmodule

// File: rtl/nor_id_mux.sv
`timescale 1ns/1ps
module nor_id_mux
   import nor_cmd_pkg::*;
#(
   parameter logic [7:0] DEV_CODE = 8'hD4
) (
   input  logic       id_mode,
   input  logic       sel_dev,
   input  logic [7:0] arr_rdata,
   output logic [7:0] rd_data
);
   always_comb begin
      if (!id_mode)     rd_data = arr_rdata;
      else if (sel_dev) rd_data = DEV_CODE;
      else              rd_data = MFR_CODE;
   end
endmodule

// File: rtl/nor_cmd_decoder.sv
`timescale 1ns/1ps
module nor_cmd_decoder
   import nor_cmd_pkg::*;
#(
   parameter int         ADDR_W      = 16,
   parameter int         SECTOR_BITS = 12,
   parameter logic [7:0] DEV_CODE    = 8'hD4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              exec_busy,
   input  logic [7:0]        arr_rdata,
   output logic              req_valid,
   output logic [1:0]        req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   output logic              id_mode,
   output logic [7:0]        rd_data
);
   generate
      if (ADDR_W < CMP_W) begin : g_bad_addr_w
         $error("ADDR_W must cover the 15-bit command address window");
      end
      if ((SECTOR_BITS < 1) || (SECTOR_BITS >= ADDR_W)) begin : g_bad_sector
         $error("SECTOR_BITS must lie between 1 and ADDR_W-1");
      end
   endgenerate

   logic [N_KEYS-1:0] key_hit;

   generate
      for (genvar k = 0; k < N_KEYS; k++) begin : g_key
         nor_cyc_match #(
            .MATCH_ADDR (KEY_ADRS[k*CMP_W +: CMP_W]),
            .MATCH_DATA (KEY_DATAS[k*8 +: 8])
         ) u_match (
            .cmp_addr (addr[CMP_W-1:0]),
            .cmp_data (wdata),
            .hit      (key_hit[k])
         );
      end
   endgenerate

   nor_seq_fsm #(
      .ADDR_W      (ADDR_W),
      .SECTOR_BITS (SECTOR_BITS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .busy      (exec_busy),
      .addr      (addr),
      .wdata     (wdata),
      .key_hit   (key_hit),
      .req_valid (req_valid),
      .req_op    (req_op),
      .req_addr  (req_addr),
      .req_data  (req_data),
      .id_mode   (id_mode)
   );

   nor_id_mux #(
      .DEV_CODE (DEV_CODE)
   ) u_idmux (
      .id_mode   (id_mode),
      .sel_dev   (addr[0]),
      .arr_rdata (arr_rdata),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/nor_cmd_chk.sv
`timescale 1ns/1ps
module nor_cmd_chk #(
   parameter int         ADDR_W      = 16,
   parameter int         SECTOR_BITS = 12,
   parameter logic [7:0] DEV_CODE    = 8'hD4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [14:0]       cmd_addr,
   input logic [7:0]        wdata,
   input logic              exec_busy,
   input logic [7:0]        arr_rdata,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [ADDR_W-1:0] req_addr,
   input logic              id_mode,
   input logic [7:0]        rd_data
);
   // R8: a busy cycle never leads to a request
   p_busy_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exec_busy |=> !req_valid);

   // R8: the flag is frozen across a busy cycle
   p_busy_id_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exec_busy |=> $stable(id_mode));

   // R2: every request follows an accepted write
   p_req_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> ($past(wr_en) && !$past(exec_busy)));

   // R2: a request always carries a real operation code
   p_req_op_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_op != 2'b00));

   // R3: sector requests are aligned and came from a 30h write
   p_sector_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b10) |->
         ((req_addr[SECTOR_BITS-1:0] == '0) && ($past(wdata) == 8'h30)));

   // R4: array erase targets address 0 and came from 10h at 5555h
   p_chip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b11) |->
         ((req_addr == '0) && ($past(wdata) == 8'h10) && ($past(cmd_addr) == 15'h5555)));

   // R5: entering identification mode needs a 90h write
   p_id_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> ($past(wdata) == 8'h90));

   // R6: leaving identification mode needs an F0h write
   p_id_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(id_mode) |-> ($past(wdata) == 8'hF0));

   // R5: read path selection
   p_id_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      id_mode |-> (rd_data == (cmd_addr[0] ? DEV_CODE : 8'hBF)));

   p_arr_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !id_mode |-> (rd_data == arr_rdata));
endmodule

bind nor_cmd_decoder nor_cmd_chk #(
   .ADDR_W      (ADDR_W),
   .SECTOR_BITS (SECTOR_BITS),
   .DEV_CODE    (DEV_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .cmd_addr  (addr[14:0]),
   .wdata     (wdata),
   .exec_busy (exec_busy),
   .arr_rdata (arr_rdata),
   .req_valid (req_valid),
   .req_op    (req_op),
   .req_addr  (req_addr),
   .id_mode   (id_mode),
   .rd_data   (rd_data)
);

// File: tb/tb_nor_cmd_decoder.sv
`timescale 1ns/1ps
module tb_nor_cmd_decoder;
   localparam int         AW  = 17;
   localparam logic [7:0] DEV = 8'hD5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   logic          exec_busy = 1'b0;
   logic [7:0]    arr_rdata = 8'h3C;
   logic          req_valid;
   logic [1:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [7:0]    req_data;
   logic          id_mode;
   logic [7:0]    rd_data;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   typedef struct packed {
      logic [1:0]    op;
      logic [AW-1:0] a;
      logic [7:0]    d;
   } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;

   nor_cmd_decoder #(.ADDR_W(AW), .SECTOR_BITS(12), .DEV_CODE(DEV)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .exec_busy(exec_busy), .arr_rdata(arr_rdata), .req_valid(req_valid),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .id_mode(id_mode), .rd_data(rd_data));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever a request appears
   always @(negedge clk) begin
      if (rst_n && req_valid && !done) begin
         if (q.size() == 0) begin
            chk(1'b0, "R7 unexpected request", {req_op, 5'd0, req_addr[7:0], req_data}, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(req_op == e.op, "R2/R3/R4 req_op", req_op, e.op);
            chk(req_addr == e.a, "R2/R3/R4 req_addr", req_addr, e.a);
            chk(req_data == e.d, "R2/R3/R4 req_data", req_data, e.d);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock(input logic [AW-1:0] hi);
      wr(hi | 17'h05555, 8'hAA);
      wr(hi | 17'h02AAA, 8'h55);
   endtask

   task automatic push(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d);
      exp_t e;
      e.op = op; e.a = a; e.d = d;
      q.push_back(e);
   endtask

   task automatic drained(input string tag);
      @(negedge clk);
      @(negedge clk);
      chk(q.size() == 0, tag, q.size(), 0);
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
      addr = a;
      #1;
      chk(rd_data == exp, tag, rd_data, exp);
   endtask

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(id_mode == 1'b0, "R1 id_mode after reset", id_mode, 0);
      chk(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);
      rd_chk(17'h00000, 8'h3C, "R1 array read after reset");
      wr(17'h00123, 8'h44);
      drained("R1 lone write gives no request");

      // R2 program
      unlock(17'h0);
      wr(17'h05555, 8'hA0);
      push(2'b01, 17'h12345, 8'h5A);
      wr(17'h12345, 8'h5A);
      drained("R2 program request");

      // R2 upper address bits outside the compare window
      unlock(17'h10000);
      wr(17'h15555, 8'hA0);
      push(2'b01, 17'h00777, 8'hC3);
      wr(17'h00777, 8'hC3);
      drained("R2 upper bits ignored");

      // R3 sector erase
      unlock(17'h0);
      wr(17'h05555, 8'h80);
      unlock(17'h0);
      push(2'b10, 17'h1A000, 8'h30);
      wr(17'h1A7F3, 8'h30);
      drained("R3 sector erase");

      // R4 array erase
      unlock(17'h0);
      wr(17'h05555, 8'h80);
      unlock(17'h0);
      push(2'b11, 17'h00000, 8'h10);
      wr(17'h05555, 8'h10);
      drained("R4 array erase");

      // R4 10h at wrong address -> nothing
      unlock(17'h0);
      wr(17'h05555, 8'h80);
      unlock(17'h0);
      wr(17'h01234, 8'h10);
      drained("R4 10h off 5555h ignored");

      // R7 wrong third byte aborts
      unlock(17'h0);
      wr(17'h05555, 8'h77);
      wr(17'h00100, 8'hAB);
      drained("R7 abort after bad command byte");

      // R7 wrong first address aborts
      wr(17'h02AAA, 8'hAA);
      wr(17'h02AAA, 8'h55);
      wr(17'h05555, 8'hA0);
      wr(17'h00200, 8'hCD);
      drained("R7 abort after bad first cycle");

      // R7 sequence restarts cleanly after an abort
      push(2'b01, 17'h00300, 8'hEE);
      unlock(17'h0);
      wr(17'h05555, 8'hA0);
      wr(17'h00300, 8'hEE);
      drained("R7 restart after abort");

      // R9 reads between writes
      wr(17'h05555, 8'hAA);
      addr = 17'h01111; repeat (3) @(negedge clk);
      wr(17'h02AAA, 8'h55);
      addr = 17'h1FFFF; repeat (2) @(negedge clk);
      wr(17'h05555, 8'hA0);
      addr = 17'h00000; repeat (4) @(negedge clk);
      push(2'b01, 17'h0ABCD, 8'h12);
      wr(17'h0ABCD, 8'h12);
      drained("R9 reads do not disturb sequence");

      // R5 identification entry and reads
      unlock(17'h0);
      wr(17'h05555, 8'h90);
      chk(id_mode == 1'b1, "R5 id entry", id_mode, 1);
      rd_chk(17'h00000, 8'hBF, "R5 manufacturer byte");
      rd_chk(17'h00001, DEV, "R5 device byte");
      rd_chk(17'h10000, 8'hBF, "R5 manufacturer at high address");

      // R6 single-write exit
      wr(17'h00ABC, 8'hF0);
      chk(id_mode == 1'b0, "R6 single exit", id_mode, 0);
      rd_chk(17'h00001, 8'h3C, "R5 array read after exit");

      // R6 three-cycle exit
      unlock(17'h0);
      wr(17'h05555, 8'h90);
      chk(id_mode == 1'b1, "R5 id re-entry", id_mode, 1);
      unlock(17'h0);
      wr(17'h05555, 8'hF0);
      chk(id_mode == 1'b0, "R6 three-cycle exit", id_mode, 0);

      // R8 exit ignored while busy
      unlock(17'h0);
      wr(17'h05555, 8'h90);
      exec_busy = 1'b1;
      wr(17'h00000, 8'hF0);
      chk(id_mode == 1'b1, "R8 single exit ignored while busy", id_mode, 1);
      unlock(17'h0);
      wr(17'h05555, 8'hF0);
      chk(id_mode == 1'b1, "R8 three-cycle exit ignored while busy", id_mode, 1);
      exec_busy = 1'b0;
      wr(17'h00000, 8'hF0);
      chk(id_mode == 1'b0, "R8 exit accepted after busy", id_mode, 0);

      // R8 busy write in mid-sequence neither advances nor aborts
      unlock(17'h0);
      exec_busy = 1'b1;
      wr(17'h00333, 8'h99);
      exec_busy = 1'b0;
      wr(17'h05555, 8'hA0);
      push(2'b01, 17'h00444, 8'h11);
      wr(17'h00444, 8'h11);
      drained("R8 busy write held sequence");

      // R8 busy on the data cycle raises nothing
      unlock(17'h0);
      wr(17'h05555, 8'hA0);
      exec_busy = 1'b1;
      wr(17'h00555, 8'h22);
      drained("R8 no request while busy");
      exec_busy = 1'b0;
      push(2'b01, 17'h00666, 8'h33);
      wr(17'h00666, 8'h33);
      drained("R8 data accepted after busy");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule